// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It combines two predictors. The first is indexed by a shift register that holds the outcomes of the most recent branches across the whole program. The second is a two-level predictor that works on one branch at a time. Its first level keeps a short outcome history for each branch address. That history then selects a counter in its second level. A third table of small saturating counters, indexed by branch address, decides which of the two predictors gives the final answer for that branch.

The block has two ports. A fetch stage presents a branch address and reads the predicted direction in the same cycle, through combinational logic. When the branch resolves, the pipeline presents its address and its real outcome on the update port. The block trains both predictors and adjusts the selector on the next clock edge. It predicts direction only. It does not predict targets and it does not recover speculative history.

Top module: `tourn_predictor`

## Requirements
- R1: After reset, every global and local counter holds weakly not-taken, all histories are zero, and every selector weakly favours the local side. As a result, every address predicts not-taken.
- R2: A selector value in the upper half (2 or 3 for two bits) picks the global prediction. A value in the lower half (0 or 1) picks the local prediction. `predTaken` equals the prediction of the picked side.
- R3: A global counter is two bits wide. It predicts taken at values 2 and above. It counts up on a taken outcome and down on a not-taken outcome, and it saturates at 3 and at 0. It is indexed directly by the global history.
- R4: A local counter is three bits wide. It predicts taken at values 4 and above. It counts up on a taken outcome and down on a not-taken outcome, and it saturates at 7 and at 0.
- R5: A selector changes only when the two sides predicted differently for the updated branch. It then steps one count towards the side that was right, saturating at 0 and at 3.
- R6: Every update shifts the real outcome into bit 0 of the global history. The older bits move up one place and the oldest bit is dropped.
- R7: The per-branch history is selected by the low address bits. On each update that history shifts the outcome into bit 0, and it then selects the local counter. The selector table uses its own, wider field of low address bits.
- R8: While `updValid` is low, no counter, history or selector changes, whatever `updPc` and `updTaken` carry.
- R9: The prediction is combinational from the stored state. An update presented in a cycle does not change a prediction made in that same cycle. It takes effect from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| predPc | input | PC_W | Address of the branch being predicted |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| updValid | input | 1 | Update strobe for a resolved branch |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Real outcome, 1 = taken |

## Verification
The bench first sweeps every address after reset. It then runs four kinds of outcome streams:
- A branch that is always taken drives the local counters into saturation.
- A strictly alternating branch makes the global and local sides disagree, so the selector moves.
- Several branches with different periodic patterns show whether the per-branch histories stay apart by address.
- A long pseudo-random stream over many addresses exercises the selector saturation ends.

Each update also checks the prediction made in the same cycle against the state before the update. This separates a correct edge-timed update from one that leaks through combinationally. Idle cycles that carry noise on the update lines, followed by a full address sweep, show whether `updValid` gates every table.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

  // strobes from control to datapath for one resolved branch
  typedef struct packed {
    logic trainEn;    // train both sides and shift both histories
    logic chooseEn;   // sides disagreed: move the selector
    logic chooseUp;   // step selector toward the global side
  } tournStrobe_t;

endpackage

// File: rtl/tourn_ctrl.sv
module tourn_ctrl
  import tourn_pkg::*;
(
  input  logic         updValid,
  input  logic         updTaken,
  input  logic         updGlobalVote,
  input  logic         updLocalVote,
  output tournStrobe_t stb
);

  logic disagree;

  always_comb begin
    disagree     = updGlobalVote ^ updLocalVote;
    stb.trainEn  = updValid;
    stb.chooseEn = updValid & disagree;
    stb.chooseUp = (updGlobalVote == updTaken);
  end

endmodule

// File: rtl/tourn_datapath.sv
module tourn_datapath
  import tourn_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int GHIST_W      = 12,
  parameter int LHT_IDX_W    = 10,
  parameter int LHIST_W      = 10,
  parameter int CHOOSE_IDX_W = 12,
  parameter int GCTR_W       = 2,
  parameter int LCTR_W       = 3,
  parameter int SEL_W        = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken,
  input  tournStrobe_t    stb,
  output logic            updGlobalVote,
  output logic            updLocalVote
);

  localparam int GSIZE = 1 << GHIST_W;
  localparam int LSIZE = 1 << LHIST_W;
  localparam int HSIZE = 1 << LHT_IDX_W;
  localparam int CSIZE = 1 << CHOOSE_IDX_W;
  localparam logic [GCTR_W-1:0] GMAX  = '1;
  localparam logic [LCTR_W-1:0] LMAX  = '1;
  localparam logic [SEL_W-1:0]  SMAX  = '1;
  localparam logic [GCTR_W-1:0] GINIT = GMAX >> 1;   // weakly not-taken
  localparam logic [LCTR_W-1:0] LINIT = LMAX >> 1;
  localparam logic [SEL_W-1:0]  SINIT = SMAX >> 1;   // weakly local

  logic [GCTR_W-1:0]  gTab  [GSIZE];
  logic [LCTR_W-1:0]  lTab  [LSIZE];
  logic [LHIST_W-1:0] lhTab [HSIZE];
  logic [SEL_W-1:0]   chTab [CSIZE];
  logic [GHIST_W-1:0] ghist;

  // predict side
  logic [LHT_IDX_W-1:0]    pLi;
  logic [CHOOSE_IDX_W-1:0] pCi;
  logic [LHIST_W-1:0]      pLh;
  logic                    pGv, pLv, pSel;

  // update side
  logic [LHT_IDX_W-1:0]    uLi;
  logic [CHOOSE_IDX_W-1:0] uCi;
  logic [LHIST_W-1:0]      uLh;
  logic [GCTR_W-1:0]       uGc;
  logic [LCTR_W-1:0]       uLc;
  logic [SEL_W-1:0]        uSc;

  always_comb begin
    pLi  = predPc[LHT_IDX_W-1:0];
    pCi  = predPc[CHOOSE_IDX_W-1:0];
    pLh  = lhTab[pLi];
    pGv  = gTab[ghist][GCTR_W-1];
    pLv  = lTab[pLh][LCTR_W-1];
    pSel = chTab[pCi][SEL_W-1];
    predTaken = pSel ? pGv : pLv;
  end

  always_comb begin
    uLi = updPc[LHT_IDX_W-1:0];
    uCi = updPc[CHOOSE_IDX_W-1:0];
    uLh = lhTab[uLi];
    uGc = gTab[ghist];
    uLc = lTab[uLh];
    uSc = chTab[uCi];
    updGlobalVote = uGc[GCTR_W-1];
    updLocalVote  = uLc[LCTR_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < GSIZE; i++) gTab[i]  <= GINIT;
      for (int i = 0; i < LSIZE; i++) lTab[i]  <= LINIT;
      for (int i = 0; i < HSIZE; i++) lhTab[i] <= '0;
      for (int i = 0; i < CSIZE; i++) chTab[i] <= SINIT;
      ghist <= '0;
    end else begin
      if (stb.trainEn) begin
        if (updTaken) begin
          if (uGc != GMAX) gTab[ghist] <= uGc + 1'b1;
          if (uLc != LMAX) lTab[uLh]   <= uLc + 1'b1;
        end else begin
          if (uGc != '0) gTab[ghist] <= uGc - 1'b1;
          if (uLc != '0) lTab[uLh]   <= uLc - 1'b1;
        end
        lhTab[uLi] <= {uLh[LHIST_W-2:0], updTaken};
        ghist      <= {ghist[GHIST_W-2:0], updTaken};
      end
      if (stb.chooseEn) begin
        if (stb.chooseUp) begin
          if (uSc != SMAX) chTab[uCi] <= uSc + 1'b1;
        end else begin
          if (uSc != '0) chTab[uCi] <= uSc - 1'b1;
        end
      end
    end
  end

  // R8: idle cycles leave the global history alone
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.trainEn |=> $stable(ghist));

  // R6: newest outcome lands in bit 0
  p_ghist_newest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.trainEn |=> ghist[0] == $past(updTaken));

  // R5: an update with agreeing sides leaves the selector as it was
  p_sel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.trainEn && !stb.chooseEn) |=> chTab[$past(uCi)] == $past(uSc));

  // R4: local counter sticks at its top value
  p_local_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.trainEn && updTaken && uLc == LMAX) |=> lTab[$past(uLh)] == LMAX);

  // R3: global counter sticks at zero
  p_global_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.trainEn && !updTaken && uGc == '0) |=> gTab[$past(ghist)] == '0);

endmodule

// File: rtl/tourn_predictor.sv
module tourn_predictor
  import tourn_pkg::*;
#(
  parameter int PC_W         = 32,
  parameter int GHIST_W      = 12,
  parameter int LHT_IDX_W    = 10,
  parameter int LHIST_W      = 10,
  parameter int CHOOSE_IDX_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  tournStrobe_t stb;
  logic         updGlobalVote;
  logic         updLocalVote;

  tourn_ctrl u_ctrl (
    .updValid      (updValid),
    .updTaken      (updTaken),
    .updGlobalVote (updGlobalVote),
    .updLocalVote  (updLocalVote),
    .stb           (stb)
  );

  tourn_datapath #(
    .PC_W         (PC_W),
    .GHIST_W      (GHIST_W),
    .LHT_IDX_W    (LHT_IDX_W),
    .LHIST_W      (LHIST_W),
    .CHOOSE_IDX_W (CHOOSE_IDX_W),
    .GCTR_W       (2),
    .LCTR_W       (3),
    .SEL_W        (2)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .predPc        (predPc),
    .predTaken     (predTaken),
    .updPc         (updPc),
    .updTaken      (updTaken),
    .stb           (stb),
    .updGlobalVote (updGlobalVote),
    .updLocalVote  (updLocalVote)
  );

endmodule

// File: tb/tourn_predictor_test.sv
module tourn_predictor_test;

  localparam int PC_W = 8;
  localparam int GH   = 4;
  localparam int LI   = 3;
  localparam int LH   = 4;
  localparam int CI   = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] predPc = '0;
  logic            predTaken;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic            updTaken = 1'b0;

  int total = 0;
  int bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference state, built from the requirements
  int          mg [1<<GH];
  int          ml [1<<LH];
  int          mh [1<<LI];
  int          mc [1<<CI];
  int          gh;

  always #4 clk = ~clk;   // 125 MHz

  tourn_predictor #(
    .PC_W(PC_W), .GHIST_W(GH), .LHT_IDX_W(LI), .LHIST_W(LH), .CHOOSE_IDX_W(CI)
  ) uut (
    .clk(clk), .rst_n(rst_n), .predPc(predPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  function automatic logic mGlob();
    return mg[gh] >= 2;
  endfunction

  function automatic logic mLoc(input int pc);
    return ml[mh[pc % (1<<LI)]] >= 4;
  endfunction

  function automatic logic mPred(input int pc);
    return (mc[pc % (1<<CI)] >= 2) ? mGlob() : mLoc(pc);
  endfunction

  task automatic mUpdate(input int pc, input logic t);
    int li = pc % (1<<LI);
    int ci = pc % (1<<CI);
    int lh = mh[li];
    logic gv = mg[gh] >= 2;
    logic lv = ml[lh] >= 4;
    if (gv != lv) begin
      if (gv == t) mc[ci] = (mc[ci] < 3) ? mc[ci] + 1 : 3;
      else         mc[ci] = (mc[ci] > 0) ? mc[ci] - 1 : 0;
    end
    if (t) begin
      mg[gh] = (mg[gh] < 3) ? mg[gh] + 1 : 3;
      ml[lh] = (ml[lh] < 7) ? ml[lh] + 1 : 7;
    end else begin
      mg[gh] = (mg[gh] > 0) ? mg[gh] - 1 : 0;
      ml[lh] = (ml[lh] > 0) ? ml[lh] - 1 : 0;
    end
    mh[li] = ((lh << 1) | int'(t)) % (1<<LH);
    gh     = ((gh << 1) | int'(t)) % (1<<GH);
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: predTaken=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // probe one address away from the edge
  task automatic probe(input int pc, input string tag);
    @(negedge clk);
    predPc = pc[PC_W-1:0];
    #1;
    check(predTaken, mPred(pc), tag);
  endtask

  // update; same-cycle prediction must reflect pre-update state (R9)
  task automatic upd(input int pc, input logic t, input string tag);
    @(negedge clk);
    predPc   = pc[PC_W-1:0];
    updPc    = pc[PC_W-1:0];
    updTaken = t;
    updValid = 1'b1;
    #1;
    check(predTaken, mPred(pc), "R9");
    mUpdate(pc, t);
    @(negedge clk);
    updValid = 1'b0;
    #1;
    check(predTaken, mPred(pc), tag);
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    for (int i = 0; i < (1<<GH); i++) mg[i] = 1;
    for (int i = 0; i < (1<<LH); i++) ml[i] = 3;
    for (int i = 0; i < (1<<LI); i++) mh[i] = 0;
    for (int i = 0; i < (1<<CI); i++) mc[i] = 1;
    gh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every address predicts not-taken out of reset
    for (int pc = 0; pc < (1<<PC_W); pc++) begin
      @(negedge clk);
      predPc = pc[PC_W-1:0];
      #1;
      check(predTaken, 1'b0, "R1");
    end

    // R4: one branch always taken, local counters saturate
    for (int k = 0; k < 24; k++) upd(5, 1'b1, "R4");

    // R6 / R3: alternating outcome on one branch, global side learns it
    for (int k = 0; k < 40; k++) upd(9, k[0], (k < 20) ? "R6" : "R3");

    // R5: two branches, one always-not-taken, one correlated with it
    for (int k = 0; k < 40; k++) begin
      upd(2, 1'b0, "R5");
      upd(3, (k % 3) == 0, "R5");
    end

    // R7: several branches with distinct periods, aliasing by low bits
    for (int k = 0; k < 30; k++) begin
      for (int b = 0; b < 4; b++) upd(b * 9 + 1, ((k % (b + 2)) == 0), "R7");
    end

    // R2: long pseudo-random stream, chooser exercised at both ends
    for (int k = 0; k < 600; k++) begin
      lfsr = step(lfsr);
      upd(int'(lfsr[7:0]) % 24, lfsr[15] | (lfsr[3] & lfsr[9]), "R2");
    end

    // R8: noise on update lines with strobe low, then full sweep
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      lfsr     = step(lfsr);
      updPc    = lfsr[7:0];
      updTaken = lfsr[0];
    end
    for (int pc = 0; pc < (1<<PC_W); pc++) probe(pc, "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule